// File: doc/BRIEF.md
# Bouncing Sprite Pixel Engine

This block computes the colour of one raster pixel per clock. A separate timing generator supplies the current column, the current row, a flag that is high inside the visible window, and a one-cycle frame-start pulse. The block paints a horizontal gradient as the background: blue at the left edge and red at the right edge. Over that background it overlays a 16x16 one-bit airplane bitmap in a fixed colour. Wherever the visible flag is low, the output is forced to black.

The airplane moves once per frame by a fixed step on each axis. When it reaches an edge of the visible window, it turns around on that axis. The position and direction registers belong to each instance alone and nothing outside ever corrects them. Three copies can therefore be placed side by side for redundancy, and a disturbed copy keeps its own trajectory until reset. The bitmap is computed from a closed-form shape, so no memory initialisation is needed.

Top module: `sprite_pixel_engine`

## Requirements
- R1: Whenever `visible` is low, the `pixel_rgb` value produced one cycle later is 12'h000, even if row and column fall inside the sprite.
- R2: A visible pixel outside the sprite shows the gradient. The red field `pixel_rgb[11:8]` is floor(col*16/H_VIS), the green field `[7:4]` is 0, and the blue field `[3:0]` is 15 minus red.
- R3: A visible pixel at offset (dx, dy) = (col-X, row-Y), with both offsets in 0..15, shows SPRITE_RGB (default 12'hFF0) when the bitmap bit is 1. The bit is 1 when any of these holds: dx is 7 or 8 with dy in 1..14; dy is 5..7 with dx in 1..14; dy is 12 or 13 with dx in 4..11.
- R4: Inside the 16x16 window, a bitmap bit of 0 is transparent and shows the R2 gradient.
- R5: `pixel_rgb` is registered. Inputs sampled at one rising edge determine the output after that edge.
- R6: The origin (X, Y) changes only on a clock where `frame_start` is high, and it is applied to that pixel and to the rest of the frame. While moving forward, each axis adds STEP_X or STEP_Y; while moving backward, it subtracts the step.
- R7: When moving forward and pos+step >= LIM, the axis clamps to LIM and turns backward. When moving backward and pos <= step, it clamps to 0 and turns forward. LIM is H_VIS-16 for X and V_VIS-16 for Y.
- R8: Reset (asynchronous, active low) clears `pixel_rgb` to 0, sets the origin to (0,0) and sets both axes forward. The first frame after reset therefore draws the sprite at (STEP_X, STEP_Y).
- R9: The origin always stays within 0..H_VIS-16 by 0..V_VIS-16, so every visible frame shows every set bitmap pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse at row 0, column 0 |
| visible | input | 1 | High inside the visible window |
| row | input | COORD_W | Current row |
| col | input | COORD_W | Current column |
| pixel_rgb | output | 12 | Registered colour, red in bits 11:8, green in 7:4, blue in 3:0 |

## Verification
The assertions assume the timing generator raises `frame_start` for one cycle per frame. They also assume `visible` is high only while row < V_VIS and col < H_VIS. They do not assume any spacing between frame pulses. The stimulus sweeps whole frames of a reduced 64x48 window and adds blanking columns and rows. Each frame carries exactly one pulse, at row 0 and column 0. The steps are odd (5 and 7) so that the clamp is reached off-grid on both axes. The only out-of-pattern stimulus is a blanked probe at sprite coordinates and a reset in mid-run. Both still respect the one-pulse rule.

// File: rtl/spe_pkg.sv
package spe_pkg;

    localparam int CH_W    = 4;
    localparam int SPR_DIM = 16;

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } rgb_t;

    // Closed-form airplane: fuselage, wings, tailplane
    function automatic logic plane_bit(input logic [3:0] dy, input logic [3:0] dx);
        logic body, wing, tail;
        body = (dx == 4'd7 || dx == 4'd8) && (dy >= 4'd1) && (dy <= 4'd14);
        wing = (dy >= 4'd5) && (dy <= 4'd7) && (dx >= 4'd1) && (dx <= 4'd14);
        tail = (dy == 4'd12 || dy == 4'd13) && (dx >= 4'd4) && (dx <= 4'd11);
        return body | wing | tail;
    endfunction

endpackage

// File: rtl/spe_axis_motion.sv
module spe_axis_motion #(
    parameter int W     = 10,
    parameter int LIMIT = 624,
    parameter int STEP  = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         advance,
    output logic [W-1:0] pos_q,
    output logic         fwd_q,
    output logic [W-1:0] pos_nxt
);

    typedef struct packed {
        logic [W-1:0] pos;
        logic         fwd;
    } axis_t;

    localparam axis_t AXIS_RST = '{pos: '0, fwd: 1'b1};

    axis_t st_d, st_q;
    logic [W:0] fwd_sum;

    always_comb begin
        st_d    = st_q;
        fwd_sum = {1'b0, st_q.pos} + (W+1)'(STEP);
        if (advance) begin
            if (st_q.fwd) begin
                if (fwd_sum >= (W+1)'(LIMIT)) begin
                    st_d.pos = W'(LIMIT);
                    st_d.fwd = 1'b0;
                end else begin
                    st_d.pos = fwd_sum[W-1:0];
                end
            end else begin
                if (st_q.pos <= W'(STEP)) begin
                    st_d.pos = '0;
                    st_d.fwd = 1'b1;
                end else begin
                    st_d.pos = st_q.pos - W'(STEP);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= AXIS_RST;
        else        st_q <= st_d;
    end

    assign pos_q   = st_q.pos;
    assign fwd_q   = st_q.fwd;
    assign pos_nxt = st_d.pos;

endmodule

// File: rtl/spe_background.sv
module spe_background
    import spe_pkg::*;
#(
    parameter int W     = 10,
    parameter int H_VIS = 640
) (
    input  logic [W-1:0] col,
    output rgb_t         bg
);

    logic [W+3:0] scaled;
    logic [W+3:0] level;

    always_comb begin
        scaled = {col, 4'b0000};
        level  = scaled / (W+4)'(H_VIS);
        bg.r   = level[CH_W-1:0];
        bg.g   = '0;
        bg.b   = 4'hF - level[CH_W-1:0];
    end

endmodule

// File: rtl/spe_sprite_mask.sv
module spe_sprite_mask
    import spe_pkg::*;
#(
    parameter int W = 10
) (
    input  logic [W-1:0] col,
    input  logic [W-1:0] row,
    input  logic [W-1:0] org_x,
    input  logic [W-1:0] org_y,
    output logic         hit
);

    logic [W-1:0] dx, dy;
    logic         in_x, in_y;

    always_comb begin
        dx   = col - org_x;
        dy   = row - org_y;
        in_x = (col >= org_x) && (dx[W-1:4] == '0);
        in_y = (row >= org_y) && (dy[W-1:4] == '0);
        hit  = in_x && in_y && plane_bit(dy[3:0], dx[3:0]);
    end

endmodule

// File: rtl/sprite_pixel_engine.sv
module sprite_pixel_engine
    import spe_pkg::*;
#(
    parameter int          COORD_W    = 10,
    parameter int          H_VIS      = 640,
    parameter int          V_VIS      = 480,
    parameter int          STEP_X     = 2,
    parameter int          STEP_Y     = 2,
    parameter logic [11:0] SPRITE_RGB = 12'hFF0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic               visible,
    input  logic [COORD_W-1:0] row,
    input  logic [COORD_W-1:0] col,
    output logic [11:0]        pixel_rgb
);

    localparam int X_LIM = H_VIS - SPR_DIM;
    localparam int Y_LIM = V_VIS - SPR_DIM;

    logic [1:0][COORD_W-1:0] pos_q;
    logic [1:0][COORD_W-1:0] pos_nxt;
    logic [1:0]              fwd_q;

    for (genvar a = 0; a < 2; a++) begin : g_axis
        localparam int LIM = (a == 0) ? X_LIM : Y_LIM;
        localparam int STP = (a == 0) ? STEP_X : STEP_Y;
        spe_axis_motion #(
            .W    (COORD_W),
            .LIMIT(LIM),
            .STEP (STP)
        ) u_axis (
            .clk    (clk),
            .rst_n  (rst_n),
            .advance(frame_start),
            .pos_q  (pos_q[a]),
            .fwd_q  (fwd_q[a]),
            .pos_nxt(pos_nxt[a])
        );
    end

    rgb_t bg;
    logic hit;

    spe_background #(.W(COORD_W), .H_VIS(H_VIS)) u_bg (
        .col(col),
        .bg (bg)
    );

    // next-state origin: a frame-start pixel already uses the moved sprite
    spe_sprite_mask #(.W(COORD_W)) u_mask (
        .col  (col),
        .row  (row),
        .org_x(pos_nxt[0]),
        .org_y(pos_nxt[1]),
        .hit  (hit)
    );

    rgb_t pix_d, pix_q;

    always_comb begin
        pix_d = '0;
        if (visible) pix_d = hit ? rgb_t'(SPRITE_RGB) : bg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pix_q <= '0;
        else        pix_q <= pix_d;
    end

    assign pixel_rgb = pix_q;

endmodule

// File: rtl/spe_checker.sv
module spe_checker #(
    parameter int COORD_W = 10,
    parameter int X_LIM   = 624,
    parameter int Y_LIM   = 464
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    frame_start,
    input logic                    visible,
    input logic [11:0]             pixel_rgb,
    input logic [1:0][COORD_W-1:0] pos_q,
    input logic [1:0]              fwd_q
);

    // R1
    blank_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !visible |=> (pixel_rgb == 12'h000));

    // R6
    hold_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(pos_q));

    // R6
    step_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (pos_q[0] != $past(pos_q[0])) && (pos_q[1] != $past(pos_q[1])));

    // R9
    in_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q[0] <= COORD_W'(X_LIM)) && (pos_q[1] <= COORD_W'(Y_LIM)));

    // R7
    turn_x_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fwd_q[0]) |-> (pos_q[0] == '0 || pos_q[0] == COORD_W'(X_LIM)));

    // R7
    turn_y_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fwd_q[1]) |-> (pos_q[1] == '0 || pos_q[1] == COORD_W'(Y_LIM)));

endmodule

bind sprite_pixel_engine spe_checker #(
    .COORD_W(COORD_W),
    .X_LIM  (X_LIM),
    .Y_LIM  (Y_LIM)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_start(frame_start),
    .visible    (visible),
    .pixel_rgb  (pixel_rgb),
    .pos_q      (pos_q),
    .fwd_q      (fwd_q)
);

// File: tb/tb_sprite_pixel_engine.sv
module tb_sprite_pixel_engine;

    localparam int          CLK_PERIOD = 10;
    localparam int          CW  = 10;
    localparam int          HV  = 64;
    localparam int          VV  = 48;
    localparam int          SX  = 5;
    localparam int          SY  = 7;
    localparam logic [11:0] SPR = 12'hFF0;
    localparam int          XL  = HV - 16;
    localparam int          YL  = VV - 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_start = 1'b0;
    logic          visible = 1'b0;
    logic [CW-1:0] row = '0;
    logic [CW-1:0] col = '0;
    logic [11:0]   pixel_rgb;

    sprite_pixel_engine #(
        .COORD_W(CW), .H_VIS(HV), .V_VIS(VV),
        .STEP_X(SX), .STEP_Y(SY), .SPRITE_RGB(SPR)
    ) dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .visible(visible), .row(row), .col(col), .pixel_rgb(pixel_rgb)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;

    int    mx, my;
    bit    mfx, mfy;
    logic [11:0] exp_q;
    bit    exp_valid = 0;
    string exp_tag;
    int    frame_hits;
    int    plane_pop;

    task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: pixel_rgb=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit plane(input int dy, input int dx);
        return ((dx == 7 || dx == 8) && dy >= 1 && dy <= 14) ||
               (dy >= 5 && dy <= 7 && dx >= 1 && dx <= 14) ||
               ((dy == 12 || dy == 13) && dx >= 4 && dx <= 11);
    endfunction

    function automatic bit in_win(input int r, input int c);
        return c >= mx && c < mx + 16 && r >= my && r < my + 16;
    endfunction

    function automatic logic [11:0] gradient(input int c);
        int red;
        red = (c * 16) / HV;
        return {4'(red), 4'h0, 4'(15 - red)};
    endfunction

    task automatic model_reset();
        mx = 0; my = 0; mfx = 1; mfy = 1;
    endtask

    // R6 R7: one step per axis, clamp and turn at the limits
    task automatic model_step();
        if (mfx) begin
            if (mx + SX >= XL) begin mx = XL; mfx = 0; end else mx += SX;
        end else begin
            if (mx <= SX) begin mx = 0; mfx = 1; end else mx -= SX;
        end
        if (mfy) begin
            if (my + SY >= YL) begin my = YL; mfy = 0; end else my += SY;
        end else begin
            if (my <= SY) begin my = 0; mfy = 1; end else my -= SY;
        end
    endtask

    // R5: result of inputs driven here is checked at the next falling edge
    task automatic drive(input int r, input int c, input bit vis, input bit fs, input string tag);
        @(negedge clk);
        if (exp_valid) chk(exp_tag, pixel_rgb, exp_q);
        row = CW'(r); col = CW'(c); visible = vis; frame_start = fs;
        if (fs) model_step();
        if (!vis) begin
            exp_q = 12'h000; exp_tag = "R1/R5";
        end else if (in_win(r, c) && plane(r - my, c - mx)) begin
            exp_q = SPR; exp_tag = "R3/R6/R7"; frame_hits++;
        end else if (in_win(r, c)) begin
            exp_q = gradient(c); exp_tag = "R4";
        end else begin
            exp_q = gradient(c); exp_tag = "R2/R5";
        end
        if (tag != "") exp_tag = tag;
        exp_valid = 1;
    endtask

    task automatic flush();
        @(negedge clk);
        if (exp_valid) chk(exp_tag, pixel_rgb, exp_q);
        exp_valid = 0;
        frame_start = 0; visible = 0;
    endtask

    task automatic run_frame();
        frame_hits = 0;
        for (int r = 0; r < VV + 2; r++)
            for (int c = 0; c < HV + 4; c++)
                drive(r, c, (r < VV) && (c < HV), (r == 0) && (c == 0), "");
        flush();
        // R9: the whole bitmap stays inside the window every frame
        checks++;
        if (frame_hits != plane_pop) begin
            errors++;
            $display("FAIL R9: sprite pixels=%0d expected=%0d", frame_hits, plane_pop);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        plane_pop = 0;
        for (int y = 0; y < 16; y++)
            for (int x = 0; x < 16; x++)
                if (plane(y, x)) plane_pop++;
        model_reset();

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R8 reset output", pixel_rgb, 12'h000);
        rst_n = 1'b1;

        // R8: first frame after reset draws at (STEP_X, STEP_Y)
        drive(0, 0, 1, 1, "R8");
        drive(SY + 5, SX + 1, 1, 0, "R8 wing");
        drive(SY + 8, SX + 7, 1, 0, "R8 body");
        drive(SY, SX, 1, 0, "R8 transparent corner");
        flush();
        chk("R8 origin model", 12'(mx * 256 + my), 12'(SX * 256 + SY));

        for (int f = 0; f < 22; f++) run_frame();

        // R1: blanked even on an opaque sprite pixel
        drive(my + 6, mx + 7, 0, 0, "R1 blank over sprite");
        drive(my + 6, mx + 7, 1, 0, "R3 same pixel visible");
        flush();

        // R8: reset mid-run restarts the trajectory
        @(negedge clk);
        rst_n = 1'b0;
        model_reset();
        @(negedge clk);
        chk("R8 mid-run reset output", pixel_rgb, 12'h000);
        rst_n = 1'b1;
        for (int f = 0; f < 3; f++) run_frame();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule